// File: doc/BRIEF.md
# Parallel Host Register Slave

This block is the slave end of a byte-wide host port in which address and data share one bus. The host's write strobe is the only clock the port uses, and every transfer takes one strobe cycle. At each rising strobe edge a phase-select level says whether the byte on the bus is a register address or data. A separate direction level chooses whether a data phase writes or reads. Register writes act at once, and a read presents the addressed register on the bus while the strobe is low.

The held address stays in place until the next address phase, so the host can send one address and then any number of data transfers to the same location. A port-disable input turns the whole port off. While it is high every port input counts as idle-high, every strobe is ignored, and the slave never enables its bus driver. The bidirectional bus is split into an input, an output and an output enable, and the pad ring joins them.

Top module: `hpb_slave`

## Requirements
- R1: After the active-low reset, every register location and the held address are 0, and the bus output enable is low.
- R2: On a rising strobe edge with the port enabled and phase-select high (1), the bus byte becomes the held address.
- R3: On a rising strobe edge with the port enabled, phase-select low (0) and direction high (1 = write), the bus byte is stored in the register at the held address, and a following read returns it.
- R4: While the port is enabled, phase-select is low, direction is low (0 = read) and the strobe is low, the output enable is high and the bus output carries the addressed register. A read does not change any register.
- R5: Data phases leave the held address unchanged, so consecutive data transfers after one address phase all reach the same register.
- R6: The output enable is low during address phases, during write data phases and whenever the strobe is high.
- R7: While port-disable is high, strobes change neither the held address nor any register, and the output enable stays low.
- R8: The register file has 256 distinct byte locations, addressed 0x00 through 0xFF. The lowest and highest addresses hold separate values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_stb_i | input | 1 | Host latch strobe; transfers complete on its rising edge |
| port_dis_i | input | 1 | High disables the port; all inputs are treated as high |
| phase_i | input | 1 | High = address phase, low = data phase |
| dir_i | input | 1 | High = write, low = read |
| bus_i | input | 8 | Byte received from the shared bus |
| bus_o | output | 8 | Byte the slave puts on the shared bus (idle-high when not driving) |
| bus_oe_o | output | 1 | Slave drive enable for the shared bus |

## Verification
The checker tests the output-enable conditions continuously: it is never high during an address phase, while the strobe is high, or while the port is disabled. On every strobe edge it also checks that an address phase loads the bus byte, that a data phase keeps the address, that a write lands in the addressed register, and that a read or a disabled strobe leaves the state unchanged. What only the bench scenarios show is the value that comes back on the bus. That covers reset contents read back over the port, repeated writes to one held address, the two end addresses kept apart, and state that survives a disabled stretch and can be read once the port is enabled again.

// File: rtl/hpb_pkg.sv
package hpb_pkg;

   // Kind of transfer the current strobe cycle carries
   typedef enum logic [1:0] {
      XFER_NONE = 2'd0,
      XFER_ADDR = 2'd1,
      XFER_WR   = 2'd2,
      XFER_RD   = 2'd3
   } xfer_e;

   function automatic xfer_e classify(input logic dis, input logic ph, input logic dw);
      if (dis)     return XFER_NONE;
      else if (ph) return XFER_ADDR;
      else if (dw) return XFER_WR;
      else         return XFER_RD;
   endfunction

endpackage

// File: rtl/hpb_in_mask.sv
module hpb_in_mask
   import hpb_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              port_dis_i,
   input  logic              stb_i,
   input  logic              phase_i,
   input  logic              dir_i,
   input  logic [DATA_W-1:0] bus_i,
   output logic              stb_m_o,
   output logic [DATA_W-1:0] bus_m_o,
   output xfer_e             xfer_o
);

   logic phase_m;
   logic dir_m;

   // A disabled port sees every pin at its pulled-up level
   always_comb begin
      stb_m_o = port_dis_i | stb_i;
      phase_m = port_dis_i | phase_i;
      dir_m   = port_dis_i | dir_i;
      bus_m_o = port_dis_i ? {DATA_W{1'b1}} : bus_i;
      xfer_o  = classify(port_dis_i, phase_m, dir_m);
   end

endmodule

// File: rtl/hpb_addr_latch.sv
module hpb_addr_latch
   import hpb_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 8
) (
   input  logic              rst_ni,
   input  logic              stb_i,
   input  xfer_e             xfer_i,
   input  logic [DATA_W-1:0] bus_m_i,
   output logic [ADDR_W-1:0] addr_o
);

   always_ff @(posedge stb_i or negedge rst_ni) begin
      if (!rst_ni)
         addr_o <= '0;
      else if (xfer_i == XFER_ADDR)
         addr_o <= bus_m_i[ADDR_W-1:0];
   end

endmodule

// File: rtl/hpb_regfile.sv
module hpb_regfile
   import hpb_pkg::*;
#(
   parameter int DATA_W         = 8,
   parameter int ADDR_W         = 8,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic              rst_ni,
   input  logic              stb_i,
   input  xfer_e             xfer_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o
);

   localparam int DEPTH = 1 << ADDR_W;

   logic              wr_hit;
   logic [DATA_W-1:0] loc_q [DEPTH];

   assign wr_hit = (xfer_i == XFER_WR);

   for (genvar i = 0; i < DEPTH; i++) begin : g_loc
      logic [DATA_W-1:0] q;
      logic              sel;
      assign sel = wr_hit && (addr_i == ADDR_W'(i));
      if (CLEAR_ON_RESET) begin : g_clr
         always_ff @(posedge stb_i or negedge rst_ni) begin
            if (!rst_ni)  q <= '0;
            else if (sel) q <= wdata_i;
         end
      end else begin : g_keep
         always_ff @(posedge stb_i) begin
            if (sel) q <= wdata_i;
         end
      end
      assign loc_q[i] = q;
   end

   assign rdata_o = loc_q[addr_i];

endmodule

// File: rtl/hpb_bus_drv.sv
module hpb_bus_drv
   import hpb_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter bit IDLE_HIGH = 1'b1
) (
   input  xfer_e             xfer_i,
   input  logic              stb_m_i,
   input  logic [DATA_W-1:0] rdata_i,
   output logic [DATA_W-1:0] bus_o,
   output logic              oe_o
);

   // Drive only during the low half of a read data cycle
   assign oe_o = (xfer_i == XFER_RD) && !stb_m_i;

   if (IDLE_HIGH) begin : g_idle_hi
      assign bus_o = oe_o ? rdata_i : {DATA_W{1'b1}};
   end else begin : g_raw
      assign bus_o = rdata_i;
   end

endmodule

// File: rtl/hpb_slave.sv
module hpb_slave
   import hpb_pkg::*;
#(
   parameter int DATA_W         = 8,
   parameter int ADDR_W         = 8,
   parameter bit CLEAR_ON_RESET = 1'b1,
   parameter bit IDLE_HIGH      = 1'b1
) (
   input  logic              rst_ni,
   input  logic              wr_stb_i,
   input  logic              port_dis_i,
   input  logic              phase_i,
   input  logic              dir_i,
   input  logic [DATA_W-1:0] bus_i,
   output logic [DATA_W-1:0] bus_o,
   output logic              bus_oe_o
);

   if (DATA_W < 1) begin : g_bad_data
      $error("hpb_slave: DATA_W must be at least 1");
   end
   if (ADDR_W < 1 || ADDR_W > DATA_W) begin : g_bad_addr
      $error("hpb_slave: ADDR_W must fit on the data bus");
   end

   logic              stb_m;
   logic [DATA_W-1:0] bus_m;
   xfer_e             xfer;
   logic [ADDR_W-1:0] held_addr;
   logic [DATA_W-1:0] rd_data;

   hpb_in_mask #(.DATA_W(DATA_W)) u_mask (
      .port_dis_i (port_dis_i),
      .stb_i      (wr_stb_i),
      .phase_i    (phase_i),
      .dir_i      (dir_i),
      .bus_i      (bus_i),
      .stb_m_o    (stb_m),
      .bus_m_o    (bus_m),
      .xfer_o     (xfer)
   );

   hpb_addr_latch #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_addr (
      .rst_ni  (rst_ni),
      .stb_i   (wr_stb_i),
      .xfer_i  (xfer),
      .bus_m_i (bus_m),
      .addr_o  (held_addr)
   );

   hpb_regfile #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CLEAR_ON_RESET(CLEAR_ON_RESET)
   ) u_regs (
      .rst_ni  (rst_ni),
      .stb_i   (wr_stb_i),
      .xfer_i  (xfer),
      .addr_i  (held_addr),
      .wdata_i (bus_m),
      .rdata_o (rd_data)
   );

   hpb_bus_drv #(.DATA_W(DATA_W), .IDLE_HIGH(IDLE_HIGH)) u_drv (
      .xfer_i  (xfer),
      .stb_m_i (stb_m),
      .rdata_i (rd_data),
      .bus_o   (bus_o),
      .oe_o    (bus_oe_o)
   );

endmodule

// File: rtl/hpb_slave_chk.sv
module hpb_slave_chk #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 8
) (
   input logic              rst_ni,
   input logic              wr_stb_i,
   input logic              port_dis_i,
   input logic              phase_i,
   input logic              dir_i,
   input logic [DATA_W-1:0] bus_i,
   input logic              bus_oe_o,
   input logic [ADDR_W-1:0] held_addr,
   input logic [DATA_W-1:0] rd_data
);

   always_comb begin
      if (rst_ni === 1'b1) begin
         // R6
         oe_addr_phase_chk: assert (!(bus_oe_o && phase_i));
         // R6
         oe_stb_high_chk: assert (!(bus_oe_o && wr_stb_i));
         // R7
         oe_disabled_chk: assert (!(bus_oe_o && port_dis_i));
      end
   end

   // R2
   addr_load_chk: assert property (@(posedge wr_stb_i) disable iff (!rst_ni)
      (!port_dis_i && phase_i) |=> (held_addr == $past(bus_i[ADDR_W-1:0])));

   // R5
   addr_keep_chk: assert property (@(posedge wr_stb_i) disable iff (!rst_ni)
      (!port_dis_i && !phase_i) |=> (held_addr == $past(held_addr)));

   // R3
   wr_land_chk: assert property (@(posedge wr_stb_i) disable iff (!rst_ni)
      (!port_dis_i && !phase_i && dir_i) |=> (rd_data == $past(bus_i)));

   // R4
   rd_keep_chk: assert property (@(posedge wr_stb_i) disable iff (!rst_ni)
      (!port_dis_i && !phase_i && !dir_i) |=> $stable(rd_data));

   // R7
   dis_keep_chk: assert property (@(posedge wr_stb_i) disable iff (!rst_ni)
      port_dis_i |=> ($stable(held_addr) && $stable(rd_data)));

endmodule

bind hpb_slave hpb_slave_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
   .rst_ni     (rst_ni),
   .wr_stb_i   (wr_stb_i),
   .port_dis_i (port_dis_i),
   .phase_i    (phase_i),
   .dir_i      (dir_i),
   .bus_i      (bus_i),
   .bus_oe_o   (bus_oe_o),
   .held_addr  (held_addr),
   .rd_data    (rd_data)
);

// File: tb/hpb_slave_test.sv
module hpb_slave_test;

   typedef struct {
      logic [7:0] val;
      string      tag;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       stb;
   logic       dis;
   logic       ph;
   logic       dw;
   logic [7:0] din;
   logic [7:0] dout;
   logic       oe;
   logic       done = 1'b0;

   int   checks = 0;
   int   errors = 0;
   exp_t expq[$];

   always #5 clk = ~clk;

   hpb_slave uut (
      .rst_ni     (rst_n),
      .wr_stb_i   (stb),
      .port_dis_i (dis),
      .phase_i    (ph),
      .dir_i      (dw),
      .bus_i      (din),
      .bus_o      (dout),
      .bus_oe_o   (oe)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic cyc(input bit p, input bit d, input logic [7:0] b);
      @(posedge clk); ph <= p; dw <= d; din <= b;
      @(posedge clk); stb <= 1'b0;
      @(posedge clk); stb <= 1'b1;
   endtask

   task automatic set_addr(input logic [7:0] a);
      cyc(1'b1, 1'b1, a);
   endtask

   task automatic wr(input logic [7:0] d);
      cyc(1'b0, 1'b1, d);
   endtask

   task automatic rd(input logic [7:0] e, input string tag);
      exp_t it;
      it.val = e;
      it.tag = tag;
      expq.push_back(it);
      cyc(1'b0, 1'b0, 8'hFF);
   endtask

   // Monitor: sampled mid-cycle, away from the strobe edges
   always @(negedge clk) begin
      if (rst_n === 1'b1) begin
         if (stb) chk(oe == 1'b0, "R6", "oe with strobe high", 32'(oe), 0);
         else if (dis) chk(oe == 1'b0, "R7", "oe while disabled", 32'(oe), 0);
         else if (ph) chk(oe == 1'b0, "R6", "oe in address phase", 32'(oe), 0);
         else if (dw) chk(oe == 1'b0, "R6", "oe in write phase", 32'(oe), 0);
         else if (expq.size() == 0) chk(1'b0, "R4", "read with nothing expected", 1, 0);
         else begin
            exp_t it;
            it = expq.pop_front();
            chk(oe == 1'b1, it.tag, "read oe", 32'(oe), 1);
            chk(dout == it.val, it.tag, "read data", 32'(dout), 32'(it.val));
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog all requirements actual=hung expected=done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; stb = 1'b1; dis = 1'b0; ph = 1'b1; dw = 1'b1; din = 8'hFF;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(oe == 1'b0, "R1", "oe during reset", 32'(oe), 0);
      @(posedge clk); rst_n <= 1'b1;

      // R1: reset contents, starting from the cleared held address
      rd(8'h00, "R1");
      set_addr(8'h80); rd(8'h00, "R1");
      set_addr(8'hFF); rd(8'h00, "R1");

      // R3: write then read back
      set_addr(8'h12); wr(8'hA5); rd(8'hA5, "R3");

      // R5: several data phases after one address; R4 read leaves it intact
      set_addr(8'h40); wr(8'h11); wr(8'h22);
      rd(8'h22, "R5"); rd(8'h22, "R4");

      // R8: both end addresses are distinct
      set_addr(8'h00); wr(8'h5A);
      set_addr(8'hFF); wr(8'hC3);
      set_addr(8'h00); rd(8'h5A, "R8");
      set_addr(8'hFF); rd(8'hC3, "R8");

      // R2: address phases select earlier written locations
      set_addr(8'h12); rd(8'hA5, "R2");
      set_addr(8'h40); rd(8'h22, "R2");

      // R7: disabled strobes are ignored
      @(posedge clk); dis <= 1'b1;
      cyc(1'b1, 1'b1, 8'h12);
      cyc(1'b0, 1'b1, 8'hEE);
      cyc(1'b0, 1'b0, 8'hFF);
      @(posedge clk); dis <= 1'b0;
      rd(8'h22, "R7");
      set_addr(8'h12); rd(8'hA5, "R7");

      repeat (4) @(posedge clk);
      chk(expq.size() == 0, "R4", "pending reads", 32'(expq.size()), 0);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule